// File: doc/BRIEF.md
# Calendar clock register core

This block keeps wall-clock time and the calendar in a small byte-addressed register file. A once-per-second strobe starts an update. The update-in-progress bit is raised for a fixed number of clock cycles. The counters then advance by one second in a single cycle, and the carry ripples through minutes, hours, day of month, weekday, month and year. Software reads and writes every byte through a synchronous port. The read data is combinational from the address.

Two run-time choices apply to the values:

- The counters can hold packed decimal (BCD) or plain binary values.
- The hours byte can be in 24-hour form, or in 12-hour form with an afternoon marker in bit 7.

Software can freeze updates while it loads a new time. At the end of each update the block raises an update-ended flag. It raises an alarm flag when the new seconds, minutes and hours equal their alarm bytes. Each flag drives an interrupt output only when its enable bit is set.

Top module: `calclk_core`

Register map:

| Address | Contents |
|---|---|
| 0 | seconds |
| 1 | seconds alarm |
| 2 | minutes |
| 3 | minutes alarm |
| 4 | hours |
| 5 | hours alarm |
| 6 | weekday |
| 7 | day of month |
| 8 | month |
| 9 | year |
| 10 | control A: bit 7 update in progress (read-only), bits 6..0 plain storage |
| 11 | control B |
| 12 | flags (read-only) |

Control B bits:

| Bit | Meaning |
|---|---|
| 7 | freeze |
| 5 | alarm interrupt enable |
| 4 | update-ended interrupt enable |
| 2 | number format: 1 binary, 0 BCD |
| 1 | hour format: 1 24-hour, 0 12-hour |

Flags register bits:

| Bit | Meaning |
|---|---|
| 7 | any enabled flag |
| 5 | alarm flag |
| 4 | update-ended flag |

## Requirements
- R1: After reset, the registers read as follows: seconds, minutes, hours, year and all alarm bytes read 0; weekday, day of month and month read 1; control A reads 0; control B reads 0x02 (BCD, 24-hour); the flags register reads 0; both interrupt outputs are low.
- R2: Timing of an update:
  - A strobe sampled with freeze clear sets control A bit 7 for exactly UIP_CYCLES clock cycles.
  - At the edge that ends those cycles, seconds advance by one, bit 7 clears and flag bit 4 sets.
  - Strobes arriving during those cycles are ignored.
- R3: In BCD mode (control B bit 2 = 0), seconds and minutes wrap from 0x59 to 0x00 and carry to the next counter (09:59:59 becomes 10:00:00).
- R4: In binary mode (control B bit 2 = 1), counters hold plain binary values: 9:59:59 becomes 10:00:00.
- R5: In 12-hour mode (control B bit 1 = 0), hours bits 6..0 run 12, 1 .. 11 and bit 7 marks afternoon:
  - 11 a.m. becomes 12 p.m. (0x92).
  - 12 p.m. becomes 1 p.m. (0x81).
  - 11 p.m. becomes 12 a.m. (0x12) and advances the day.
- R6: Rollover at the end of a day:
  - In 24-hour mode, 23:59:59 wraps hours to 0 and advances the day of month and the weekday. The weekday wraps from 7 to 1.
  - The day of month wraps to 1 after the month's length and advances the month. February has 29 days when year mod 4 is 0, otherwise 28; April, June, September and November have 30; the other months have 31.
  - Month wraps from 12 to 1 and advances the year; year wraps from 99 to 0.
- R7: While control B bit 7 is set, strobes start no update and the time is unchanged. Setting that bit during an update abandons it: no counter advances and the update-ended flag does not set.
- R8: The alarm flag (flags bit 5) sets at the end of an update when the new seconds, minutes and hours bytes equal the bytes at addresses 1, 3 and 5. Output alarm_irq is the flag ANDed with control B bit 5, and flags bit 7 reflects it in the same way.
- R9: Output upd_irq is the update-ended flag ANDed with control B bit 4.
- R10: Reading address 12 with rd_en high clears both flags on the next edge. An update ending on the same edge still sets its flags.
- R11: Three kinds of access have no effect:
  - Reads of addresses 13 and above return 0.
  - Writes to address 12 are ignored.
  - Writes to control A do not change bit 7.
- R12: A write to any time or alarm byte (addresses 0..9) is visible on the next cycle, whether or not updates are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Write strobe for the byte at addr |
| rd_en | input | 1 | Read strobe; a read at address 12 clears the flags |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| upd_irq | output | 1 | Update-ended interrupt, gated by its enable |
| alarm_irq | output | 1 | Alarm interrupt, gated by its enable |

## Verification
The checker watches the following on every cycle:
- The update-in-progress bit never stays high for more than UIP_CYCLES cycles.
- Every completed update leaves the update-ended flag set.
- Freeze prevents a new update from starting.
- Seconds change only through a write or an update.
- Each interrupt output is low whenever its enable bit is clear.

Only the directed scenarios can show the following:
- The counting arithmetic: BCD against binary, and the 12-hour afternoon marker.
- Month lengths, leap years and the century wrap.
- Matching of the alarm bytes.
- Flags cleared by a read.
- Inertness of unmapped addresses.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

    localparam int NTIME     = 10;
    localparam int T_SEC     = 0;
    localparam int T_SEC_AL  = 1;
    localparam int T_MIN     = 2;
    localparam int T_MIN_AL  = 3;
    localparam int T_HOUR    = 4;
    localparam int T_HOUR_AL = 5;
    localparam int T_WDAY    = 6;
    localparam int T_MDAY    = 7;
    localparam int T_MON     = 8;
    localparam int T_YEAR    = 9;

    localparam logic [7:0] ADDR_CTLA  = 8'd10;
    localparam logic [7:0] ADDR_CTLB  = 8'd11;
    localparam logic [7:0] ADDR_FLAGS = 8'd12;

    localparam int B_FREEZE = 7;
    localparam int B_AIE    = 5;
    localparam int B_UIE    = 4;
    localparam int B_BIN    = 2;
    localparam int B_24H    = 1;

    typedef logic [NTIME-1:0][7:0] tarr_t;

    function automatic logic [7:0] to_bin(input logic [7:0] v, input logic bin);
        logic [7:0] r;
        if (bin) r = v;
        else     r = ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
        return r;
    endfunction

    function automatic logic [7:0] from_bin(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return bin ? v : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        logic [7:0] r;
        case (mon)
            8'd2:                     r = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  r = 8'd30;
            default:                  r = 8'd31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/calclk_seq.sv
module calclk_seq #(
    parameter int UIP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic busy,
    output logic commit,
    output logic abort
);
    localparam int CW = $clog2(UIP_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d  = seq_q;
        abort  = seq_q.busy && freeze;
        commit = seq_q.busy && !freeze && (seq_q.cnt == '0);
        if (abort || commit) begin
            seq_d.busy = 1'b0;
            seq_d.cnt  = '0;
        end else if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end else if (tick && !freeze) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = CW'(UIP_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;

endmodule

// File: rtl/calclk_bump.sv
module calclk_bump
    import calclk_pkg::*;
(
    input  tarr_t cur,
    input  logic  bin,
    input  logic  h24,
    output tarr_t nxt
);
    logic [7:0] s, m, hb, h12, wd, md, mo, yr, mlen;
    logic [7:0] s_n, m_n, hb_n, wd_n, md_n, mo_n, yr_n, h12o, henc;
    logic       pm, c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        s  = to_bin(cur[T_SEC], bin);
        m  = to_bin(cur[T_MIN], bin);
        wd = to_bin(cur[T_WDAY], bin);
        md = to_bin(cur[T_MDAY], bin);
        mo = to_bin(cur[T_MON], bin);
        yr = to_bin(cur[T_YEAR], bin);
        h12 = to_bin({1'b0, cur[T_HOUR][6:0]}, bin);
        pm  = cur[T_HOUR][7];
        if (h24) hb = to_bin(cur[T_HOUR], bin);
        else     hb = ((h12 >= 8'd12) ? 8'd0 : h12) + (pm ? 8'd12 : 8'd0);
        mlen = month_len(mo, yr);

        c_min = (s >= 8'd59);
        s_n   = c_min ? 8'd0 : s + 8'd1;
        c_hr  = c_min && (m >= 8'd59);
        m_n   = c_min ? ((m >= 8'd59) ? 8'd0 : m + 8'd1) : m;
        c_day = c_hr && (hb >= 8'd23);
        hb_n  = c_hr ? ((hb >= 8'd23) ? 8'd0 : hb + 8'd1) : hb;
        c_mon = c_day && (md >= mlen);
        md_n  = c_day ? ((md >= mlen) ? 8'd1 : md + 8'd1) : md;
        wd_n  = c_day ? ((wd >= 8'd7) ? 8'd1 : wd + 8'd1) : wd;
        c_yr  = c_mon && (mo >= 8'd12);
        mo_n  = c_mon ? ((mo >= 8'd12) ? 8'd1 : mo + 8'd1) : mo;
        yr_n  = c_yr ? ((yr >= 8'd99) ? 8'd0 : yr + 8'd1) : yr;

        h12o = (hb_n >= 8'd12) ? hb_n - 8'd12 : hb_n;
        if (h12o == 8'd0) h12o = 8'd12;
        henc = from_bin(h12o, bin);

        nxt          = cur;
        nxt[T_SEC]   = from_bin(s_n, bin);
        nxt[T_MIN]   = from_bin(m_n, bin);
        nxt[T_HOUR]  = h24 ? from_bin(hb_n, bin) : {(hb_n >= 8'd12), henc[6:0]};
        nxt[T_WDAY]  = from_bin(wd_n, bin);
        nxt[T_MDAY]  = from_bin(md_n, bin);
        nxt[T_MON]   = from_bin(mo_n, bin);
        nxt[T_YEAR]  = from_bin(yr_n, bin);
    end

endmodule

// File: rtl/calclk_core.sv
module calclk_core
    import calclk_pkg::*;
#(
    parameter int UIP_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       upd_irq,
    output logic       alarm_irq
);
    typedef struct packed {
        tarr_t      t;
        logic [6:0] a_lo;
        logic [7:0] b;
        logic       f_al;
        logic       f_up;
    } st_t;

    st_t   st_q, st_d;
    tarr_t bumped;
    logic  busy, commit, abort, alarm_hit;
    logic  any_irq;

    calclk_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .freeze (st_q.b[B_FREEZE]),
        .busy   (busy),
        .commit (commit),
        .abort  (abort)
    );

    calclk_bump u_bump (
        .cur (st_q.t),
        .bin (st_q.b[B_BIN]),
        .h24 (st_q.b[B_24H]),
        .nxt (bumped)
    );

    always_comb begin
        st_d      = st_q;
        alarm_hit = (bumped[T_SEC]  == st_q.t[T_SEC_AL]) &&
                    (bumped[T_MIN]  == st_q.t[T_MIN_AL]) &&
                    (bumped[T_HOUR] == st_q.t[T_HOUR_AL]);
        if (rd_en && addr == ADDR_FLAGS) begin
            st_d.f_al = 1'b0;
            st_d.f_up = 1'b0;
        end
        if (commit && !abort) begin
            st_d.t    = bumped;
            st_d.f_up = 1'b1;
            if (alarm_hit) st_d.f_al = 1'b1;
        end
        if (wr_en) begin
            for (int i = 0; i < NTIME; i++) begin
                if (addr == 8'(i)) st_d.t[i] = wdata;
            end
            if (addr == ADDR_CTLA) st_d.a_lo = wdata[6:0];
            if (addr == ADDR_CTLB) st_d.b    = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.t[T_WDAY]  <= 8'h01;
            st_q.t[T_MDAY]  <= 8'h01;
            st_q.t[T_MON]   <= 8'h01;
            st_q.b          <= 8'h02;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_irq   = st_q.f_up & st_q.b[B_UIE];
    assign alarm_irq = st_q.f_al & st_q.b[B_AIE];
    assign any_irq   = upd_irq | alarm_irq;

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NTIME; i++) begin
            if (addr == 8'(i)) rdata = st_q.t[i];
        end
        if (addr == ADDR_CTLA)  rdata = {busy, st_q.a_lo};
        if (addr == ADDR_CTLB)  rdata = st_q.b;
        if (addr == ADDR_FLAGS) rdata = {any_irq, 1'b0, st_q.f_al, st_q.f_up, 4'h0};
    end

endmodule

// File: rtl/calclk_core_chk.sv
module calclk_core_chk #(
    parameter int UIP_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       uip,
    input logic       set_bit,
    input logic       aie,
    input logic       uie,
    input logic       upd_flag,
    input logic [7:0] sec,
    input logic       upd_irq,
    input logic       alarm_irq
);
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run_q <= 0;
        else if (uip) run_q <= run_q + 1;
        else          run_q <= 0;
    end

    p_uip_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        uip |-> (run_q < UIP_CYCLES));

    p_uip_end_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(uip) && !$past(set_bit)) |-> upd_flag);

    p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !uip) |=> $stable(sec));

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bit && !uip) |=> !uip);

    p_alarm_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> aie);

    p_upd_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> uie);

endmodule

bind calclk_core calclk_core_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .uip       (busy),
    .set_bit   (st_q.b[7]),
    .aie       (st_q.b[5]),
    .uie       (st_q.b[4]),
    .upd_flag  (st_q.f_up),
    .sec       (st_q.t[0]),
    .upd_irq   (upd_irq),
    .alarm_irq (alarm_irq)
);

// File: tb/test_calclk_core.sv
module test_calclk_core;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       upd_irq, alarm_irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    calclk_core #(.UIP_CYCLES(N)) i_calclk_core (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .upd_irq(upd_irq), .alarm_irq(alarm_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata === exp, req, rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr_flags();
        @(negedge clk);
        addr = 8'd12; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick_wait();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        repeat (N) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(8'd4, h); wr(8'd2, m); wr(8'd0, s);
    endtask

    task automatic set_date(input logic [7:0] wd, input logic [7:0] md, input logic [7:0] mo, input logic [7:0] yr);
        wr(8'd6, wd); wr(8'd7, md); wr(8'd8, mo); wr(8'd9, yr);
    endtask

    task automatic t_reset();
        logic [7:0] exp [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h02};
        for (int i = 0; i < 12; i++) expect_reg(8'(i), exp[i], "R1 reset value");
        expect_reg(8'd12, 8'h00, "R1 flags after reset");
        chk(upd_irq === 1'b0, "R1 upd_irq", {7'd0, upd_irq}, 8'h00);
        chk(alarm_irq === 1'b0, "R1 alarm_irq", {7'd0, alarm_irq}, 8'h00);
    endtask

    task automatic t_write();
        wr(8'd0, 8'h42);
        expect_reg(8'd0, 8'h42, "R12 seconds write");
        wr(8'd3, 8'h17);
        expect_reg(8'd3, 8'h17, "R12 alarm byte write");
        wr(8'd11, 8'h82);
        wr(8'd2, 8'h33);
        expect_reg(8'd2, 8'h33, "R12 write while frozen");
        wr(8'd11, 8'h02);
        wr(8'd3, 8'h00);
    endtask

    task automatic t_uip();
        wr(8'd0, 8'h05);
        clr_flags();
        @(negedge clk);
        tick_1hz = 1'b1; addr = 8'd10;
        @(negedge clk);
        tick_1hz = 1'b0;
        #1;
        chk(rdata[7] === 1'b1, "R2 uip first cycle", rdata, 8'h80);
        for (int i = 1; i < N; i++) begin
            @(negedge clk);
            #1;
            chk(rdata[7] === 1'b1, "R2 uip held", rdata, 8'h80);
        end
        @(negedge clk);
        #1;
        chk(rdata[7] === 1'b0, "R2 uip cleared", rdata, 8'h00);
        expect_reg(8'd0, 8'h06, "R2 seconds advanced");
        expect_reg(8'd12, 8'h10, "R2 update flag");
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tick_1hz = 1'b0;
        repeat (N + 3) @(negedge clk);
        expect_reg(8'd0, 8'h07, "R2 strobe during update ignored");
    endtask

    task automatic t_bcd();
        set_time(8'h09, 8'h59, 8'h59);
        tick_wait();
        expect_reg(8'd0, 8'h00, "R3 bcd sec wrap");
        expect_reg(8'd2, 8'h00, "R3 bcd min wrap");
        expect_reg(8'd4, 8'h10, "R3 bcd hour carry");
    endtask

    task automatic t_bin();
        wr(8'd11, 8'h06);
        set_time(8'd9, 8'd59, 8'd59);
        tick_wait();
        expect_reg(8'd0, 8'd0, "R4 bin sec wrap");
        expect_reg(8'd4, 8'd10, "R4 bin hour carry");
        set_date(8'd3, 8'd31, 8'd12, 8'd99);
        set_time(8'd23, 8'd59, 8'd59);
        tick_wait();
        expect_reg(8'd9, 8'd0, "R4 bin year wrap");
        expect_reg(8'd8, 8'd1, "R4 bin month wrap");
        wr(8'd11, 8'h02);
    endtask

    task automatic t_12h();
        wr(8'd11, 8'h00);
        set_date(8'h02, 8'h05, 8'h03, 8'h21);
        set_time(8'h11, 8'h59, 8'h59);
        tick_wait();
        expect_reg(8'd4, 8'h92, "R5 11am to 12pm");
        set_time(8'h92, 8'h59, 8'h59);
        tick_wait();
        expect_reg(8'd4, 8'h81, "R5 12pm to 1pm");
        set_time(8'h91, 8'h59, 8'h59);
        tick_wait();
        expect_reg(8'd4, 8'h12, "R5 11pm to 12am");
        expect_reg(8'd7, 8'h06, "R5 day advance at midnight");
        wr(8'd11, 8'h02);
    endtask

    task automatic t_cal();
        set_date(8'h07, 8'h28, 8'h02, 8'h23);
        set_time(8'h23, 8'h59, 8'h59);
        tick_wait();
        expect_reg(8'd4, 8'h00, "R6 hour wrap");
        expect_reg(8'd7, 8'h01, "R6 feb 28 non-leap");
        expect_reg(8'd8, 8'h03, "R6 month advance");
        expect_reg(8'd6, 8'h01, "R6 weekday wrap");
        set_date(8'h02, 8'h28, 8'h02, 8'h24);
        set_time(8'h23, 8'h59, 8'h59);
        tick_wait();
        expect_reg(8'd7, 8'h29, "R6 leap feb 29");
        expect_reg(8'd6, 8'h03, "R6 weekday step");
        set_date(8'h02, 8'h30, 8'h04, 8'h24);
        set_time(8'h23, 8'h59, 8'h59);
        tick_wait();
        expect_reg(8'd8, 8'h05, "R6 april 30 days");
        set_date(8'h02, 8'h31, 8'h12, 8'h99);
        set_time(8'h23, 8'h59, 8'h59);
        tick_wait();
        expect_reg(8'd9, 8'h00, "R6 year wrap");
        expect_reg(8'd8, 8'h01, "R6 month wrap");
        expect_reg(8'd7, 8'h01, "R6 day wrap");
    endtask

    task automatic t_freeze();
        wr(8'd11, 8'h82);
        wr(8'd0, 8'h10);
        clr_flags();
        @(negedge clk);
        tick_1hz = 1'b1; addr = 8'd10;
        @(negedge clk);
        tick_1hz = 1'b0;
        #1;
        chk(rdata[7] === 1'b0, "R7 no uip when frozen", rdata, 8'h00);
        repeat (N + 1) @(negedge clk);
        expect_reg(8'd0, 8'h10, "R7 frozen seconds");
        wr(8'd11, 8'h02);
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0; addr = 8'd11; wdata = 8'h82; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (N + 1) @(negedge clk);
        expect_reg(8'd0, 8'h10, "R7 aborted update");
        expect_reg(8'd12, 8'h00, "R7 no flag after abort");
        expect_reg(8'd10, 8'h00, "R7 uip dropped after abort");
        wr(8'd11, 8'h02);
    endtask

    task automatic t_alarm();
        wr(8'd11, 8'h22);
        wr(8'd1, 8'h30); wr(8'd3, 8'h00); wr(8'd5, 8'h00);
        set_time(8'h00, 8'h00, 8'h29);
        clr_flags();
        tick_wait();
        chk(alarm_irq === 1'b1, "R8 alarm_irq on match", {7'd0, alarm_irq}, 8'h01);
        expect_reg(8'd12, 8'hB0, "R8 flags on match");
        clr_flags();
        tick_wait();
        chk(alarm_irq === 1'b0, "R8 no alarm on mismatch", {7'd0, alarm_irq}, 8'h00);
        expect_reg(8'd12, 8'h10, "R8 flags on mismatch");
        wr(8'd11, 8'h02);
        wr(8'd0, 8'h29);
        clr_flags();
        tick_wait();
        chk(alarm_irq === 1'b0, "R8 alarm gated", {7'd0, alarm_irq}, 8'h00);
        expect_reg(8'd12, 8'h30, "R8 flag set without enable");
    endtask

    task automatic t_upd();
        wr(8'd11, 8'h12);
        clr_flags();
        chk(upd_irq === 1'b0, "R9 upd_irq low before update", {7'd0, upd_irq}, 8'h00);
        tick_wait();
        chk(upd_irq === 1'b1, "R9 upd_irq after update", {7'd0, upd_irq}, 8'h01);
        expect_reg(8'd12, 8'h90, "R9 flags with enable");
        clr_flags();
        chk(upd_irq === 1'b0, "R10 upd_irq after read clear", {7'd0, upd_irq}, 8'h00);
        expect_reg(8'd12, 8'h00, "R10 flags cleared");
        wr(8'd11, 8'h02);
    endtask

    task automatic t_misc();
        expect_reg(8'd13, 8'h00, "R11 addr 13 reads 0");
        expect_reg(8'hFF, 8'h00, "R11 addr 255 reads 0");
        wr(8'd12, 8'hFF);
        expect_reg(8'd12, 8'h00, "R11 flags not writable");
        wr(8'd10, 8'hFF);
        expect_reg(8'd10, 8'h7F, "R11 uip bit not writable");
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got %02h expected %02h", 8'h01, 8'h00);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_uip();
        t_bcd();
        t_bin();
        t_12h();
        t_cal();
        t_freeze();
        t_alarm();
        t_upd();
        t_misc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule